// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Error-Tagged Queue

This block receives asynchronous serial characters on a single input line and queues them for a host. A one-cycle enable pulse at sixteen times the bit rate paces all sampling. A falling edge starts a frame. The line is checked again in the middle of the start bit, and a glitch that has already returned high is dropped. The block then takes the configured number of data bits, least significant first, an optional parity bit and one stop bit, each sampled in the middle of its bit period.

Every received character is written into a 16-deep queue. Each entry holds the data byte and three tags: parity mismatch, missing stop bit, and line break. The host sees the oldest entry and its tags on the read port and removes it with a one-cycle read strobe. A character that arrives while the queue is full is dropped, and a sticky overrun flag is raised. When automatic flow control is enabled, the request-to-send output drops once the fill level reaches a selectable threshold.

Top module: `rxq_channel`

## Requirements
- R1: After reset the queue is empty (`rx_avail`=0, `rx_level`=0), `rx_overrun` is 0 and `rts_o` is 1.
- R2: A low level on `rx_in` that is high again at the eighth enable pulse after it was detected is treated as noise, and nothing is queued.
- R3: Data width is set by `cfg_len` (0=5, 1=6, 2=7, 3=8 bits). Bits arrive least significant first, and the stored byte is right-justified with its unused upper bits at zero.
- R4: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets the entry's `rd_perr`.
- R5: A stop bit sampled low sets the entry's `rd_ferr`. The receiver then waits for the line to go high before it looks for another start bit.
- R6: A frame that is low throughout, across data, parity and stop, queues exactly one entry with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0, even if the line stays low longer.
- R7: The queue holds 16 entries in arrival order. `rd_data` and its tags show the oldest entry, `rd_en` removes it, and `rx_level` never exceeds 16 and changes by at most one per cycle.
- R8: A character completing while the queue is full is discarded, and the queued entries are kept. `rx_overrun` is set and stays set until a `stat_rd` pulse clears it.
- R9: With `cfg_auto_rts`=1, `rts_o` is 0 while `rx_level` is at or above the threshold chosen by `cfg_rts_lvl` (0=1, 1=4, 2=8, 3=14), and 1 below it. With `cfg_auto_rts`=0, `rts_o` is 1.
- R10: Line activity has no effect while `tick16` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data width code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_auto_rts | input | 1 | Enable threshold-driven RTS |
| cfg_rts_lvl | input | 2 | RTS threshold code |
| rd_en | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error tag |
| rd_ferr | output | 1 | Head entry framing error tag |
| rd_brk | output | 1 | Head entry break tag |
| rx_avail | output | 1 | Queue holds at least one entry |
| rx_level | output | 5 | Queue fill level |
| rx_overrun | output | 1 | Sticky overrun flag |
| rts_o | output | 1 | Request to send, 1 = ready to accept |

## Verification
The assertions check the queue bookkeeping on every cycle. They cover the bound on the fill level and its single-step movement, overrun rising only when the queue was already full, and the flag staying set until a status read. They also check that a break entry at the head carries zero data and a framing tag, and that RTS is asserted while the queue is empty. The bench's scenarios are needed for the serial side: bit order, width and parity encodings, noise rejection at mid start bit, a long break yielding a single entry, discard on overrun with the older contents intact, each RTS threshold, and insensitivity to the line while the enable is held low.

// File: rtl/rxq_pkg.sv
// Shared types for the receive channel.
// Assumes an entry carries one byte plus three error tags.
package rxq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    // Map the RTS threshold code to a fill level.
    function automatic int unsigned rts_limit(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_sampler.sv
// Frame receiver: synchronises the line and walks start, data, parity and
// stop bits on the oversampling enable. It emits one entry per frame.
// Assumes the configuration inputs stay steady while a frame is in flight.
module rxq_sampler
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick16,
    input  logic      rx_in,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      char_valid,
    output rx_entry_t char_ent
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic             pbit;
    logic [1:0]       sync;
    logic             rx_s;
    logic [7:0]       data_j;
    logic             is_brk;

    assign rx_s = sync[1];

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_in};
    end

    // Right-justify the shifted data according to the width code.
    always_comb begin
        case (cfg_len)
            2'd0:    data_j = shreg >> 3;
            2'd1:    data_j = shreg >> 2;
            2'd2:    data_j = shreg >> 1;
            default: data_j = shreg;
        endcase
        is_brk = (data_j == 8'd0) && !(cfg_par_en && pbit) && !rx_s;
    end

    // Frame state machine, advanced only on enable pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            char_valid <= 1'b0;
            char_ent   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick16) begin
                case (st)
                    ST_IDLE: if (!rx_s) begin
                        st    <= ST_START;
                        cnt   <= '0;
                        shreg <= '0;
                        pbit  <= 1'b0;
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx_s ? ST_IDLE : ST_DATA;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[7:1]};
                            if (bitn == 3'(4 + cfg_len))
                                st <= cfg_par_en ? ST_PAR : ST_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            pbit <= rx_s;
                            st   <= ST_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt           <= '0;
                            char_valid    <= 1'b1;
                            char_ent.data <= data_j;
                            char_ent.brk  <= is_brk;
                            char_ent.ferr <= !rx_s;
                            char_ent.perr <= cfg_par_en && !is_brk &&
                                             ((^data_j) ^ pbit ^ cfg_par_odd);
                            st            <= rx_s ? ST_IDLE : ST_HOLD;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_HOLD: if (rx_s) st <= ST_IDLE;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxq_fifo.sv
// Show-ahead queue of tagged entries with an explicit fill count.
// Assumes the caller never pushes when full or pops when empty.
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_entry_t                  push_ent,
    input  logic                       pop,
    output rx_entry_t                  head_ent,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign head_ent = mem[rd_ptr];

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_ent;
    end

    // Pointer and count upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - LVL_W'(1);
        end
    end

endmodule

// File: rtl/rxq_flow.sv
// Admission and flow control: gates pushes on a full queue, keeps the
// sticky overrun flag and drives RTS from the fill threshold.
module rxq_flow
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       char_valid,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    input  logic                       stat_rd,
    input  logic                       cfg_auto_rts,
    input  logic [1:0]                 cfg_rts_lvl,
    output logic                       push,
    output logic                       overrun,
    output logic                       rts_o
);
    logic full;

    // Admission and threshold decode.
    always_comb begin
        full  = (32'(level) == DEPTH);
        push  = char_valid && !full;
        rts_o = !cfg_auto_rts || (32'(level) < rts_limit(cfg_rts_lvl));
    end

    // Sticky overrun: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (char_valid && full) overrun <= 1'b1;
        else if (stat_rd)            overrun <= 1'b0;
    end

endmodule

// File: rtl/rxq_channel.sv
// Receive channel top: frame receiver, tagged queue and flow control.
// Assumes tick16 is a one-cycle pulse at 16x the bit rate.
module rxq_channel
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_auto_rts,
    input  logic [1:0] cfg_rts_lvl,
    input  logic       rd_en,
    input  logic       stat_rd,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       rx_avail,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic       rx_overrun,
    output logic       rts_o
);
    rx_entry_t char_ent;
    rx_entry_t head_ent;
    logic      char_valid;
    logic      push;
    logic      pop;

    // Output decode of the head entry and the pop guard.
    always_comb begin
        rx_avail = (rx_level != '0);
        pop      = rd_en && rx_avail;
        rd_data  = head_ent.data;
        rd_perr  = head_ent.perr;
        rd_ferr  = head_ent.ferr;
        rd_brk   = head_ent.brk;
    end

    rxq_sampler #(.OSR(OSR)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .char_valid(char_valid), .char_ent(char_ent)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(char_ent),
        .pop(pop), .head_ent(head_ent), .level(rx_level)
    );

    rxq_flow #(.DEPTH(DEPTH)) u_flow (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .level(rx_level),
        .stat_rd(stat_rd), .cfg_auto_rts(cfg_auto_rts), .cfg_rts_lvl(cfg_rts_lvl),
        .push(push), .overrun(rx_overrun), .rts_o(rts_o)
    );

endmodule

// File: rtl/rxq_channel_chk.sv
// Property checker for the receive channel, bound to the top module.
module rxq_channel_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic                       rx_overrun,
    input logic                       stat_rd,
    input logic                       rts_o,
    input logic                       rx_avail,
    input logic                       rd_brk,
    input logic                       rd_ferr,
    input logic [7:0]                 rd_data
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_level) <= DEPTH); // R7

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level != $past(rx_level)) |->
        (rx_level == $past(rx_level) + LVL_W'(1) ||
         rx_level + LVL_W'(1) == $past(rx_level))); // R7

    AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> (32'($past(rx_level)) == DEPTH)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !stat_rd) |=> rx_overrun); // R8

    AST_BRK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && rd_brk) |-> (rd_data == 8'd0 && rd_ferr)); // R6

    AST_RTS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> rts_o); // R9

endmodule

bind rxq_channel rxq_channel_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_overrun(rx_overrun),
    .stat_rd(stat_rd), .rts_o(rts_o), .rx_avail(rx_avail), .rd_brk(rd_brk),
    .rd_ferr(rd_ferr), .rd_data(rd_data)
);

// File: tb/rxq_channel_tb_top.sv
module rxq_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic       flip;
        logic       stopb;
        logic [7:0] din;
        logic [7:0] dexp;
        logic       perr;
        logic       ferr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h1F, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2D, 8'h2D, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55, 8'h55, 1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b1, 1'b0},
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 8'h81, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 8'h7E, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_on = 1'b1;
    logic ph = 1'b0;
    logic tick16;
    logic rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 1'b0;
    logic cfg_par_odd = 1'b0;
    logic cfg_auto_rts = 1'b0;
    logic [1:0] cfg_rts_lvl = 2'd0;
    logic rd_en = 1'b0;
    logic stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, rx_avail, rx_overrun, rts_o;
    logic [4:0] rx_level;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) ph <= ~ph;
    assign tick16 = tick_on & ph;

    rxq_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_auto_rts(cfg_auto_rts), .cfg_rts_lvl(cfg_rts_lvl),
        .rd_en(rd_en), .stat_rd(stat_rd), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .rx_avail(rx_avail),
        .rx_level(rx_level), .rx_overrun(rx_overrun), .rts_o(rts_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bit_time();
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nb,
                                    input logic odd, input logic flip);
        logic p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= d[i];
        return p ^ odd ^ flip;
    endfunction

    task automatic send(input logic [7:0] d, input int nb, input logic pen,
                        input logic pbit, input logic stopb);
        rx_in = 1'b0; bit_time();
        for (int i = 0; i < nb; i++) begin rx_in = d[i]; bit_time(); end
        if (pen) begin rx_in = pbit; bit_time(); end
        rx_in = stopb; bit_time();
        rx_in = 1'b1; bit_time();
    endtask

    task automatic pop();
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    endtask

    task automatic send8(input logic [7:0] d);
        send(d, 8, 1'b0, 1'b0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 avail", rx_avail, 0);
        chk("R1 level", rx_level, 0);
        chk("R1 overrun", rx_overrun, 0);
        chk("R1 rts", rts_o, 1);

        // Table walk: formats, parity and framing (R3 R4 R5)
        foreach (VECS[k]) begin
            cfg_len = VECS[k].len;
            cfg_par_en = VECS[k].pen;
            cfg_par_odd = VECS[k].podd;
            send(VECS[k].din, 5 + int'(VECS[k].len), VECS[k].pen,
                 par_of(VECS[k].din, 5 + int'(VECS[k].len), VECS[k].podd, VECS[k].flip),
                 VECS[k].stopb);
            chk($sformatf("R7 avail vec%0d", k), rx_avail, 1);
            chk($sformatf("R3 data vec%0d", k), rd_data, VECS[k].dexp);
            chk($sformatf("R4 perr vec%0d", k), rd_perr, VECS[k].perr);
            chk($sformatf("R5 ferr vec%0d", k), rd_ferr, VECS[k].ferr);
            chk($sformatf("R6 brk vec%0d", k), rd_brk, 0);
            pop();
            chk($sformatf("R7 drained vec%0d", k), rx_level, 0);
        end
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R2: short glitch rejected, then a real frame still received
        rx_in = 1'b0; repeat (8) @(negedge clk); rx_in = 1'b1;
        bit_time(); bit_time();
        chk("R2 glitch ignored", rx_level, 0);
        send8(8'h5A);
        chk("R2 frame after glitch", rd_data, 8'h5A);
        pop();

        // R10: no enable, no reception
        tick_on = 1'b0;
        rx_in = 1'b0; repeat (12) bit_time(); rx_in = 1'b1; bit_time();
        tick_on = 1'b1;
        bit_time(); bit_time();
        chk("R10 no tick no entry", rx_level, 0);

        // R6: long break yields one entry
        cfg_par_en = 1'b1;
        rx_in = 1'b0; repeat (14) bit_time(); rx_in = 1'b1;
        bit_time(); bit_time();
        chk("R6 break count", rx_level, 1);
        chk("R6 break data", rd_data, 0);
        chk("R6 break tag", rd_brk, 1);
        chk("R6 break ferr", rd_ferr, 1);
        chk("R6 break perr", rd_perr, 0);
        pop();
        cfg_par_en = 1'b0;

        // R8: fill, overflow, sticky flag, order preserved
        for (int i = 0; i < 16; i++) send8(8'(i + 1));
        chk("R7 full level", rx_level, 16);
        chk("R9 rts manual", rts_o, 1);
        chk("R8 no overrun yet", rx_overrun, 0);
        send8(8'hEE);
        chk("R8 overrun set", rx_overrun, 1);
        chk("R8 level kept", rx_level, 16);
        bit_time();
        chk("R8 overrun sticky", rx_overrun, 1);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
        chk("R8 overrun cleared", rx_overrun, 0);
        for (int i = 0; i < 16; i++) begin
            chk($sformatf("R7 order %0d", i), rd_data, i + 1);
            pop();
        end
        chk("R7 empty after drain", rx_avail, 0);

        // R9: automatic RTS thresholds
        cfg_auto_rts = 1'b1; cfg_rts_lvl = 2'd1;
        for (int i = 0; i < 3; i++) send8(8'h30);
        chk("R9 below 4", rts_o, 1);
        send8(8'h31);
        chk("R9 at 4", rts_o, 0);
        pop();
        chk("R9 back below 4", rts_o, 1);
        cfg_rts_lvl = 2'd0; @(negedge clk);
        chk("R9 thr 1", rts_o, 0);
        cfg_rts_lvl = 2'd3; @(negedge clk);
        chk("R9 thr 14", rts_o, 1);
        cfg_rts_lvl = 2'd2; @(negedge clk);
        chk("R9 thr 8", rts_o, 1);
        cfg_auto_rts = 1'b0; cfg_rts_lvl = 2'd0; @(negedge clk);
        chk("R9 auto off", rts_o, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule